// File: doc/BRIEF.md
# SDRAM Bank State Checker

This block is a passive monitor placed on the command bus between an SDRAM controller and its memory. On every rising clock edge it decodes chip select, the row strobe, the column strobe, write enable, clock enable, the bank address and address bit 10. It keeps a state machine for every bank. It reports any command that the memory would not accept in its current state, and it does not drive the bus.

Each bank moves between the states idle, activating, active, reading, writing, precharging, refreshing and mode-setting. These moves follow the commands it sees and a set of minimum intervals, counted in clock cycles. Burst length comes from the last accepted mode-register command and sets when a read or write burst ends. When a command breaks the rules, the block raises a one-cycle flag together with a code. The code gives the class of error: the command came too early, the bank was in the wrong state, or not every bank was idle. The offending command is then treated as though it never happened.

Top module: `sdram_bank_monitor`

## Requirements
- R1: With `cs_n` low, the triple {`ras_n`,`cas_n`,`we_n`} decodes as 111 no-op, 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set, 110 burst stop. With `cs_n` high the cycle is a no-op. A no-op never flags and never alters a bank except through the timed countdowns.
- R2: Bank i reports its state on `bank_state[3i+2:3i]` with the codes 0 idle, 1 activating, 2 active, 3 reading, 4 writing, 5 precharging, 6 refreshing and 7 mode-setting. An activate to an idle bank makes it activating, and it becomes active TRCD cycles after the command. Any other command to an activating bank is flagged with code 3 (too early).
- R3: A read, write or burst stop addressed to an idle bank is flagged with code 1 (wrong state). An activate addressed to an active, reading or writing bank is also flagged with code 1.
- R4: An accepted mode set latches `bl_sel`, where 0, 1, 2 and 3 select 1, 2, 4 and 8 beats. A read or write to an active bank enters reading or writing, and the bank returns to active BL cycles after the command. With BL=1 it returns to active at once. A burst stop or precharge to that bank ends the burst early.
- R5: A read or write with `a10` high selects auto-precharge. When such a burst ends, the bank goes to precharging. While the burst runs, a read, write, burst stop or precharge addressed to that bank is flagged with code 1.
- R6: A precharge with `a10` low acts on the addressed bank. With `a10` high it acts on every bank. An active, reading or writing bank goes to precharging and returns to idle TRP cycles after the command. A precharge to an idle or precharging bank is a legal no-op.
- R7: Refresh with `cke` high and mode set are accepted only when every bank is idle; otherwise they are flagged with code 2. On acceptance, all banks enter refreshing for TRC cycles or mode-setting for TRSC cycles. During that time any other command is flagged with code 3.
- R8: A flagged command changes no bank state and no burst length. `illegal` and `viol_code` are registered: they show the result of the command at the clock edge that follows it, and they last one cycle.
- R9: A command sampled while the previous cycle's `cke` was low is ignored. During such a cycle, states and countdowns hold and nothing is flagged. A refresh issued with `cke` going low (self-refresh entry) is flagged with code 2 unless every bank is idle.
- R10: During reset every bank reads idle, `illegal` and `viol_code` are 0, and BL is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | BAW (2) | Bank address |
| a10 | input | 1 | Auto-precharge / all-bank select |
| bl_sel | input | 2 | Burst length code captured by mode set |
| bank_state | output | 3*NBANK (12) | Packed per-bank state codes |
| illegal | output | 1 | One-cycle violation flag |
| viol_code | output | 2 | 0 none, 1 wrong state, 2 not all idle, 3 too early |

## Verification
The hardest situation to reach is the interplay between clock enable and the bank machines. The bench has to catch a countdown partway through, freeze it for several cycles, and then show that it resumes exactly where it stopped. It must also show that self-refresh entry is refused only while a bank is open. Directed sequences reach this by moving `cke` one cycle at a time around an activate. They issue commands inside the frozen window that would otherwise be flagged. A table of vectors walks one long command stream through auto-precharge bursts, a refresh window and precharge-all.

// File: rtl/sdram_bank_monitor.sv
module sdram_bank_monitor #(
  parameter int NBANK = 4,
  parameter int TRCD  = 3,
  parameter int TRP   = 3,
  parameter int TRC   = 9,
  parameter int TRSC  = 2,
  localparam int BAW  = $clog2(NBANK)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic                 cke,
  input  logic [BAW-1:0]       ba,
  input  logic                 a10,
  input  logic [1:0]           bl_sel,
  output logic [3*NBANK-1:0]   bank_state,
  output logic                 illegal,
  output logic [1:0]           viol_code
);
  localparam logic [2:0] S_IDLE = 3'd0, S_ACTG = 3'd1, S_ACTV = 3'd2, S_RD = 3'd3,
                         S_WR = 3'd4, S_PRC = 3'd5, S_REF = 3'd6, S_MODE = 3'd7;
  localparam int M1   = (TRC > TRP) ? TRC : TRP;
  localparam int M2   = (TRCD > TRSC) ? TRCD : TRSC;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXT = (M3 > 8) ? M3 : 8;
  localparam int CW   = $clog2(MAXT + 1);

  logic [2:0]    st_q [NBANK];
  logic [2:0]    st_d [NBANK];
  logic [CW-1:0] cnt_q [NBANK];
  logic [CW-1:0] cnt_d [NBANK];
  logic          ap_q [NBANK];
  logic          ap_d [NBANK];
  logic [1:0]    bl_q;
  logic          cke_q;
  logic [1:0]    code;
  logic          all_idle;

  wire       sel   = !cs_n;
  wire [2:0] op    = {ras_n, cas_n, we_n};
  wire       c_act = sel && op == 3'b011;
  wire       c_rd  = sel && op == 3'b101;
  wire       c_wr  = sel && op == 3'b100;
  wire       c_pre = sel && op == 3'b010;
  wire       c_ref = sel && op == 3'b001;
  wire       c_mrs = sel && op == 3'b000;
  wire       c_bst = sel && op == 3'b110;

  wire [3:0]    blen    = 4'd1 << bl_q;
  wire [2:0]    ts      = st_q[ba];
  wire          tap     = ap_q[ba];
  wire          t_burst = ts == S_RD || ts == S_WR;
  wire          t_timed = ts == S_ACTG || ts == S_PRC || ts == S_REF || ts == S_MODE;

  function automatic logic [1:0] pre_chk(input logic [2:0] s, input logic ap);
    if (s == S_ACTG || s == S_REF || s == S_MODE) return 2'd3;
    if ((s == S_RD || s == S_WR) && ap) return 2'd1;
    return 2'd0;
  endfunction

  always_comb begin
    all_idle = 1'b1;
    for (int i = 0; i < NBANK; i++)
      if (st_q[i] != S_IDLE) all_idle = 1'b0;
  end

  always_comb begin
    code = 2'd0;
    if (!cke_q)                   code = 2'd0;
    else if (c_ref || c_mrs)      code = all_idle ? 2'd0 : 2'd2;
    else if (c_act)               code = t_timed ? 2'd3 : (ts == S_IDLE ? 2'd0 : 2'd1);
    else if (c_rd || c_wr || c_bst)
      code = t_timed ? 2'd3 : ((ts == S_IDLE || (t_burst && tap)) ? 2'd1 : 2'd0);
    else if (c_pre && !a10)       code = pre_chk(ts, tap);
    else if (c_pre && a10)
      for (int i = 0; i < NBANK; i++)
        if (pre_chk(st_q[i], ap_q[i]) > code) code = pre_chk(st_q[i], ap_q[i]);
  end

  always_comb begin
    for (int i = 0; i < NBANK; i++) begin
      st_d[i]  = st_q[i];
      cnt_d[i] = cnt_q[i];
      ap_d[i]  = ap_q[i];
      if (cke_q) begin
        case (st_q[i])
          S_ACTG:
            if (cnt_q[i] <= CW'(1)) st_d[i] = S_ACTV;
            else cnt_d[i] = cnt_q[i] - CW'(1);
          S_PRC, S_REF, S_MODE:
            if (cnt_q[i] <= CW'(1)) st_d[i] = S_IDLE;
            else cnt_d[i] = cnt_q[i] - CW'(1);
          S_RD, S_WR:
            if (cnt_q[i] <= CW'(1)) begin
              if (ap_q[i]) begin
                st_d[i] = S_PRC; cnt_d[i] = CW'(TRP - 1); ap_d[i] = 1'b0;
              end else st_d[i] = S_ACTV;
            end else cnt_d[i] = cnt_q[i] - CW'(1);
          default: ;
        endcase
        if (code == 2'd0) begin
          if (c_ref && cke) begin st_d[i] = S_REF;  cnt_d[i] = CW'(TRC - 1);  end
          if (c_mrs)        begin st_d[i] = S_MODE; cnt_d[i] = CW'(TRSC - 1); end
          if (ba == BAW'(i) && c_act) begin
            st_d[i] = S_ACTG; cnt_d[i] = CW'(TRCD - 1);
          end
          if (ba == BAW'(i) && (c_rd || c_wr)) begin
            if (blen == 4'd1) begin
              st_d[i] = a10 ? S_PRC : S_ACTV; cnt_d[i] = CW'(TRP - 1); ap_d[i] = 1'b0;
            end else begin
              st_d[i] = c_rd ? S_RD : S_WR; cnt_d[i] = CW'(blen - 4'd1); ap_d[i] = a10;
            end
          end
          if (ba == BAW'(i) && c_bst && (st_q[i] == S_RD || st_q[i] == S_WR)) begin
            st_d[i] = S_ACTV; ap_d[i] = 1'b0;
          end
          if (c_pre && (a10 || ba == BAW'(i)) &&
              (st_q[i] == S_ACTV || st_q[i] == S_RD || st_q[i] == S_WR)) begin
            st_d[i] = S_PRC; cnt_d[i] = CW'(TRP - 1); ap_d[i] = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBANK; i++) begin
        st_q[i] <= S_IDLE; cnt_q[i] <= '0; ap_q[i] <= 1'b0;
      end
      bl_q      <= 2'd0;
      cke_q     <= 1'b1;
      illegal   <= 1'b0;
      viol_code <= 2'd0;
    end else begin
      for (int i = 0; i < NBANK; i++) begin
        st_q[i] <= st_d[i]; cnt_q[i] <= cnt_d[i]; ap_q[i] <= ap_d[i];
      end
      if (cke_q && c_mrs && code == 2'd0) bl_q <= bl_sel;
      cke_q     <= cke;
      illegal   <= code != 2'd0;
      viol_code <= code;
    end
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_out
    assign bank_state[3*g +: 3] = st_q[g];

    a_r2_actg_exit: assert property (@(posedge clk) disable iff (!rst_n)
      st_q[g] == S_ACTG |=> (st_q[g] == S_ACTG || st_q[g] == S_ACTV));
    a_r4_burst_no_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == S_RD || st_q[g] == S_WR) |=> st_q[g] != S_IDLE);
    a_r6_prc_exit: assert property (@(posedge clk) disable iff (!rst_n)
      st_q[g] == S_PRC |=> (st_q[g] == S_PRC || st_q[g] == S_IDLE));
  end

  a_r7_ref_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q[0] == S_REF) |-> $past(all_idle));
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |=> $stable(bank_state));
  a_r9_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |=> !illegal);
endmodule

// File: tb/sdram_bank_monitor_test.sv
module sdram_bank_monitor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1, a10 = 1'b0;
  logic [1:0] ba = 2'd0, bl_sel = 2'd0;
  logic [11:0] bank_state;
  logic illegal;
  logic [1:0] viol_code;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  sdram_bank_monitor uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .a10(a10), .bl_sel(bl_sel),
    .bank_state(bank_state), .illegal(illegal), .viol_code(viol_code));

  localparam logic [2:0] NOP = 3'b111, ACT = 3'b011, RD = 3'b101, WR = 3'b100,
                         PRE = 3'b010, REF = 3'b001, MRS = 3'b000, BST = 3'b110;

  // {req[4], op[3], ba[2], a10, bl[2], code[2], state of ba[3]}
  localparam logic [16:0] VEC [36] = '{
    {4'd7, MRS, 2'd0, 1'b0, 2'd2, 2'd0, 3'd7},  // R7 mode set, BL=4
    {4'd7, NOP, 2'd0, 1'b0, 2'd0, 2'd0, 3'd0},  // R7 TRSC over
    {4'd2, ACT, 2'd1, 1'b0, 2'd0, 2'd0, 3'd1},  // R2
    {4'd2, RD,  2'd1, 1'b0, 2'd0, 2'd3, 3'd1},  // R2 too early, R8 ignored
    {4'd2, NOP, 2'd1, 1'b0, 2'd0, 2'd0, 3'd2},  // R2 active after TRCD
    {4'd4, RD,  2'd1, 1'b0, 2'd0, 2'd0, 3'd3},  // R4
    {4'd4, NOP, 2'd1, 1'b0, 2'd0, 2'd0, 3'd3},
    {4'd4, NOP, 2'd1, 1'b0, 2'd0, 2'd0, 3'd3},
    {4'd4, NOP, 2'd1, 1'b0, 2'd0, 2'd0, 3'd2},  // R4 burst of 4 done
    {4'd5, RD,  2'd1, 1'b1, 2'd0, 2'd0, 3'd3},  // R5 auto-precharge read
    {4'd5, PRE, 2'd1, 1'b0, 2'd0, 2'd1, 3'd3},  // R5
    {4'd5, BST, 2'd1, 1'b0, 2'd0, 2'd1, 3'd3},  // R5
    {4'd5, NOP, 2'd1, 1'b0, 2'd0, 2'd0, 3'd5},  // R5 into precharge
    {4'd6, NOP, 2'd1, 1'b0, 2'd0, 2'd0, 3'd5},
    {4'd6, ACT, 2'd1, 1'b0, 2'd0, 2'd3, 3'd0},  // R6 too early, idle after TRP
    {4'd3, WR,  2'd2, 1'b0, 2'd0, 2'd1, 3'd0},  // R3
    {4'd3, BST, 2'd3, 1'b0, 2'd0, 2'd1, 3'd0},  // R3
    {4'd7, REF, 2'd0, 1'b0, 2'd0, 2'd0, 3'd6},  // R7
    {4'd7, ACT, 2'd2, 1'b0, 2'd0, 2'd3, 3'd6},  // R7 too early
    {4'd7, MRS, 2'd0, 1'b0, 2'd0, 2'd2, 3'd6},  // R7 not all idle
    {4'd1, NOP, 2'd0, 1'b0, 2'd0, 2'd0, 3'd6},  // R1
    {4'd1, NOP, 2'd0, 1'b0, 2'd0, 2'd0, 3'd6},
    {4'd1, NOP, 2'd0, 1'b0, 2'd0, 2'd0, 3'd6},
    {4'd1, NOP, 2'd0, 1'b0, 2'd0, 2'd0, 3'd6},
    {4'd1, NOP, 2'd0, 1'b0, 2'd0, 2'd0, 3'd6},
    {4'd7, NOP, 2'd0, 1'b0, 2'd0, 2'd0, 3'd0},  // R7 idle after TRC
    {4'd2, ACT, 2'd0, 1'b0, 2'd0, 2'd0, 3'd1},
    {4'd2, ACT, 2'd3, 1'b0, 2'd0, 2'd0, 3'd1},
    {4'd2, NOP, 2'd0, 1'b0, 2'd0, 2'd0, 3'd2},
    {4'd2, WR,  2'd3, 1'b0, 2'd0, 2'd3, 3'd2},  // R2
    {4'd4, WR,  2'd0, 1'b0, 2'd0, 2'd0, 3'd4},  // R4
    {4'd4, BST, 2'd0, 1'b0, 2'd0, 2'd0, 3'd2},  // R4 early stop
    {4'd6, PRE, 2'd3, 1'b1, 2'd0, 2'd0, 3'd5},  // R6 all banks
    {4'd6, NOP, 2'd0, 1'b0, 2'd0, 2'd0, 3'd5},
    {4'd6, NOP, 2'd0, 1'b0, 2'd0, 2'd0, 3'd0},
    {4'd6, PRE, 2'd2, 1'b0, 2'd0, 2'd0, 3'd0}   // R6 idle bank no-op
  };

  function automatic logic [2:0] bst_of(input int b);
    return bank_state[3*b +: 3];
  endfunction

  task automatic check(input bit ok, input int req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cmd(input logic c, input logic [2:0] o, input logic [1:0] b,
                     input logic a, input logic [1:0] bl);
    cs_n = c; {ras_n, cas_n, we_n} = o; ba = b; a10 = a; bl_sel = bl;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_st(input int req, input int b, input int st, input int cd);
    check(bst_of(b) == st[2:0], req, "bank state", int'(bst_of(b)), st);
    check(viol_code == cd[1:0] && illegal == (cd != 0), req, "violation code", int'(viol_code), cd);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(bank_state == 12'd0, 10, "reset states", int'(bank_state), 0);
    check(!illegal && viol_code == 2'd0, 10, "reset flags", int'(viol_code), 0);
    rst_n = 1'b1;

    for (int k = 0; k < 36; k++) begin
      cmd(1'b0, VEC[k][12:10], VEC[k][9:8], VEC[k][7], VEC[k][6:5]);
      expect_st(int'(VEC[k][16:13]), int'(VEC[k][9:8]), int'(VEC[k][2:0]), int'(VEC[k][4:3]));
    end

    // R8: refused mode set left BL at 4, so a read lasts four cycles
    cmd(0, ACT, 0, 0, 0); cmd(0, NOP, 0, 0, 0); cmd(0, NOP, 0, 0, 0);
    cmd(0, RD, 0, 0, 0);
    cmd(0, NOP, 0, 0, 0); cmd(0, NOP, 0, 0, 0);
    expect_st(8, 0, 3, 0);
    cmd(0, NOP, 0, 0, 0);
    expect_st(8, 0, 2, 0);
    cmd(0, PRE, 0, 0, 0); cmd(0, NOP, 0, 0, 0); cmd(0, NOP, 0, 0, 0);
    expect_st(6, 0, 0, 0);

    // R4 / R5: BL=1 read with auto-precharge goes straight to precharging
    cmd(0, MRS, 0, 0, 0); cmd(0, NOP, 0, 0, 0);
    cmd(0, ACT, 2, 0, 0); cmd(0, NOP, 0, 0, 0); cmd(0, NOP, 0, 0, 0);
    cmd(0, RD, 2, 1, 0);
    expect_st(5, 2, 5, 0);
    cmd(0, NOP, 0, 0, 0); cmd(0, NOP, 0, 0, 0);
    expect_st(5, 2, 0, 0);

    // R1: deselect hides command bits
    cmd(1, ACT, 0, 0, 0);
    expect_st(1, 0, 0, 0);
    cmd(1, RD, 1, 0, 0);
    expect_st(1, 1, 0, 0);

    // R9: self-refresh entry with all idle, then frozen cycles
    cke = 1'b0; cmd(0, REF, 0, 0, 0);
    expect_st(9, 0, 0, 0);
    cmd(0, RD, 0, 0, 0);
    expect_st(9, 0, 0, 0);
    cke = 1'b1; cmd(0, RD, 0, 0, 0);
    expect_st(9, 0, 0, 0);
    cmd(0, NOP, 0, 0, 0);

    // R9: countdown freezes and resumes
    cmd(0, ACT, 1, 0, 0);
    cke = 1'b0; cmd(0, NOP, 1, 0, 0);
    expect_st(9, 1, 1, 0);
    cmd(0, NOP, 1, 0, 0); cmd(0, NOP, 1, 0, 0);
    cke = 1'b1; cmd(0, NOP, 1, 0, 0);
    expect_st(9, 1, 1, 0);
    cmd(0, NOP, 1, 0, 0);
    expect_st(9, 1, 2, 0);

    // R9: self-refresh entry with an open bank is refused
    cke = 1'b0; cmd(0, REF, 1, 0, 0);
    expect_st(9, 1, 2, 2);
    cmd(0, NOP, 1, 0, 0);
    cke = 1'b1; cmd(0, NOP, 1, 0, 0);
    cmd(0, NOP, 1, 0, 0);
    expect_st(9, 1, 2, 0);

    // R3: activate to an open bank
    cmd(0, ACT, 1, 0, 0);
    expect_st(3, 1, 2, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule